// File: doc/BRIEF.md
# Battery-free non-volatile SRAM controller

This block models a byte-wide static RAM paired with a shadow non-volatile array of the same depth. Software sees ordinary asynchronous-SRAM-style active-low controls: chip enable, output enable and write enable. These are sampled once per clock and decoded into read and write cycles. Read data comes out on a registered data bus, together with an output-enable flag that tells the pad logic when to drive. A dedicated active-low store pin, a power-fail flag from an external comparator, and a six-read address pattern can each start a bulk copy of the whole RAM into the shadow array. After every reset the shadow array is copied back into the RAM.

A dirty flag records whether any write has landed since the last bulk copy finished. Store requests from the pin and from the power-fail flag are dropped while the RAM is clean. A store started by the address pattern always runs. While a copy is in progress, reads and writes are refused. Each copy moves one word per clock. After a power-fail event the block parks itself until the next reset. Analog behaviour and access-time delays are not modelled.

Top module: `nvsram_ctrl`

## Requirements
- R1: When, in a clock cycle, `ce_n`=0, `oe_n`=0, `we_n`=1 and `hsb_n`=1 while the block is idle, then after that edge `dout_en` is 1 and `dout` holds the byte stored at `addr`.
- R2: When `ce_n`=0, `we_n`=0 and `hsb_n`=1 while idle, `din` is stored at `addr` on that edge and the RAM becomes dirty.
- R3: In any cycle in which `we_n` is 0, `dout_en` is 0 after that edge, whatever `oe_n` is.
- R4: While `busy` is 1, reads give `dout_en`=0 and writes leave the RAM contents unchanged.
- R5: Reset is synchronous and active-high. During reset `busy` is 1 and `dout_en` is 0. After reset is released, a recall copies the shadow array into the RAM, with `busy` high for DEPTH+1 cycles. The shadow array starts out all zero.
- R6: A store begins on the edge that samples its trigger and keeps `busy` high for exactly DEPTH+1 cycles.
- R7: A falling edge of `hsb_n` seen while idle starts a store only if the RAM is dirty. On a clean RAM it has no effect.
- R8: Six consecutive idle reads at the pattern addresses start a store even when the RAM is clean. The pattern is the parameter list reduced to the low address bits; for 64 words it is 0x38, 0x07, 0x20, 0x1F, 0x3F, 0x00. The store begins on the edge of the sixth read.
- R9: A read at any other address resets the pattern matcher to its first step, so the remaining steps alone start no store.
- R10: `pwr_fail`=1 while idle starts a store if the RAM is dirty and parks the block once that store ends. On a clean RAM it parks the block at once. A parked block has `busy` low and ignores reads and writes until reset.
- R11: The dirty flag is cleared when a store or recall completes, so a later `hsb_n` edge without new writes does nothing.
- R12: A falling edge of `hsb_n` during a copy is dropped and does not start a second store.
- R13: Data held in the shadow array by the last store is what the RAM reads back after the next reset. Writes made after that store are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hsb_n | input | 1 | Hardware store request, active low, edge-triggered |
| pwr_fail | input | 1 | Supply-below-threshold flag from an external comparator |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| dout_en | output | 1 | Output drivers enabled |
| busy | output | 1 | Bulk copy in progress |

## Verification
The bound checker watches several properties on every clock. It checks that a low write enable always turns the output flag off, that the output flag never rises without a decoded read in the cycle before, and that no access is accepted while a copy runs. It also checks that each accepted write leaves the RAM dirty, that a clean store-pin edge starts nothing, and that every copy lasts exactly DEPTH+1 cycles. Other behaviours need the bench's scenarios and its reference model: where the data ends up after store, recall and reset, the pattern matcher and its reset on a wrong address, dropped store-pin edges during a copy, and the parked state after a power failure.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
  typedef enum logic [1:0] {
    M_RECALL = 2'd0,
    M_IDLE   = 2'd1,
    M_STORE  = 2'd2,
    M_HALT   = 2'd3
  } nv_mode_e;

  localparam int SEQ_LEN = 6;
endpackage

// File: rtl/nvsram_access.sv
// Decodes sampled control pins into accepted read / write strobes.
module nvsram_access (
  input  logic lock,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic hsb_n,
  output logic rd_ok,
  output logic wr_ok
);
  logic sel;

  always_comb begin
    sel   = !ce_n && hsb_n && !lock;
    rd_ok = sel && !oe_n && we_n;
    wr_ok = sel && !we_n;
  end
endmodule

// File: rtl/nvsram_swseq.sv
// Matches six consecutive accepted reads against a parameter address list.
module nvsram_swseq
  import nvsram_pkg::*;
#(
  parameter int          ADDR_W = 6,
  parameter int unsigned SW_SEQ [SEQ_LEN] = '{32'h0E38, 32'h31C7, 32'h03E0,
                                              32'h3C1F, 32'h303F, 32'h0FC0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_ok,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int STEP_W = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

  logic [ADDR_W-1:0] seq_addr [SEQ_LEN];
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] want;
  logic              match;

  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_seq
    assign seq_addr[i] = ADDR_W'(SW_SEQ[i]);
  end

  always_comb begin
    want = seq_addr[0];
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (step == STEP_W'(i)) want = seq_addr[i];
    end
    match = rd_ok && (addr == want);
    hit   = match && (step == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (rd_ok) begin
      if (hit || !match) step <= '0;
      else               step <= step + 1'b1;
    end
  end
endmodule

// File: rtl/nvsram_copy_fsm.sv
// Mode control, store arbitration, dirty tracking and bulk copy sequencing.
module nvsram_copy_fsm
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_fail,
  input  logic              hsb_n,
  input  logic              sw_hit,
  input  logic              wr_ok,
  output logic              busy,
  output logic              lock,
  output logic              in_recall,
  output logic              in_store,
  output logic              dirty,
  output logic [ADDR_W-1:0] copy_raddr,
  output logic              copy_we,
  output logic [ADDR_W-1:0] copy_waddr
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH);

  nv_mode_e         mode;
  logic [CNT_W-1:0] cnt;
  logic             hsb_q;
  logic             halt_after;
  logic             hsb_fall;
  logic             done;
  logic [CNT_W-1:0] cnt_m1;

  always_comb begin
    hsb_fall   = hsb_q && !hsb_n;
    in_recall  = (mode == M_RECALL);
    in_store   = (mode == M_STORE);
    busy       = in_recall || in_store;
    lock       = (mode != M_IDLE);
    done       = (cnt == LAST);
    cnt_m1     = cnt - 1'b1;
    copy_raddr = cnt[ADDR_W-1:0];
    copy_we    = busy && (cnt != '0);
    copy_waddr = cnt_m1[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= M_RECALL;
      cnt        <= '0;
      dirty      <= 1'b0;
      hsb_q      <= 1'b1;
      halt_after <= 1'b0;
    end else begin
      hsb_q <= hsb_n;
      if (wr_ok) dirty <= 1'b1;
      case (mode)
        M_IDLE: begin
          cnt <= '0;
          if (pwr_fail) begin
            if (dirty) begin
              mode       <= M_STORE;
              halt_after <= 1'b1;
            end else begin
              mode <= M_HALT;
            end
          end else if ((hsb_fall && dirty) || sw_hit) begin
            mode       <= M_STORE;
            halt_after <= 1'b0;
          end
        end
        M_RECALL, M_STORE: begin
          if (done) begin
            cnt   <= '0;
            dirty <= 1'b0;
            mode  <= halt_after ? M_HALT : M_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: mode <= M_HALT;
      endcase
    end
  end
endmodule

// File: rtl/nvsram_mem.sv
// Working RAM and shadow array, each one write port and one registered read port.
module nvsram_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              ram_we,
  input  logic [ADDR_W-1:0] ram_wa,
  input  logic [DATA_W-1:0] ram_wd,
  input  logic [ADDR_W-1:0] ram_ra,
  output logic [DATA_W-1:0] ram_rd,
  input  logic              shd_we,
  input  logic [ADDR_W-1:0] shd_wa,
  input  logic [DATA_W-1:0] shd_wd,
  input  logic [ADDR_W-1:0] shd_ra,
  output logic [DATA_W-1:0] shd_rd
);
  logic [DATA_W-1:0] ram [DEPTH];
  logic [DATA_W-1:0] shd [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) shd[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (ram_we) ram[ram_wa] <= ram_wd;
    ram_rd <= ram[ram_ra];
  end

  always_ff @(posedge clk) begin
    if (shd_we) shd[shd_wa] <= shd_wd;
    shd_rd <= shd[shd_ra];
  end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int          ADDR_W = 6,
  parameter int          DATA_W = 8,
  parameter int unsigned SW_SEQ [SEQ_LEN] = '{32'h0E38, 32'h31C7, 32'h03E0,
                                              32'h3C1F, 32'h303F, 32'h0FC0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hsb_n,
  input  logic              pwr_fail,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              lock, rd_ok, wr_ok, sw_hit, dirty;
  logic              in_recall, in_store, copy_we;
  logic [ADDR_W-1:0] copy_raddr, copy_waddr;
  logic              ram_we, shd_we;
  logic [ADDR_W-1:0] ram_wa, ram_ra;
  logic [DATA_W-1:0] ram_wd, ram_rd, shd_rd;

  nvsram_access u_acc (
    .lock(lock), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hsb_n(hsb_n),
    .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  nvsram_swseq #(.ADDR_W(ADDR_W), .SW_SEQ(SW_SEQ)) u_seq (
    .clk(clk), .rst(rst), .rd_ok(rd_ok), .addr(addr), .hit(sw_hit)
  );

  nvsram_copy_fsm #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .hsb_n(hsb_n),
    .sw_hit(sw_hit), .wr_ok(wr_ok), .busy(busy), .lock(lock),
    .in_recall(in_recall), .in_store(in_store), .dirty(dirty),
    .copy_raddr(copy_raddr), .copy_we(copy_we), .copy_waddr(copy_waddr)
  );

  always_comb begin
    ram_we = in_recall ? copy_we    : wr_ok;
    ram_wa = in_recall ? copy_waddr : addr;
    ram_wd = in_recall ? shd_rd     : din;
    ram_ra = busy      ? copy_raddr : addr;
    shd_we = in_store && copy_we;
  end

  nvsram_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk),
    .ram_we(ram_we), .ram_wa(ram_wa), .ram_wd(ram_wd),
    .ram_ra(ram_ra), .ram_rd(ram_rd),
    .shd_we(shd_we), .shd_wa(copy_waddr), .shd_wd(ram_rd),
    .shd_ra(copy_raddr), .shd_rd(shd_rd)
  );

  assign dout = ram_rd;

  always_ff @(posedge clk) begin
    if (rst) dout_en <= 1'b0;
    else     dout_en <= rd_ok;
  end
endmodule

// File: rtl/nvsram_chk.sv
module nvsram_chk #(
  parameter int DEPTH = 64
) (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic hsb_n,
  input logic pwr_fail,
  input logic busy,
  input logic dout_en,
  input logic dirty,
  input logic rd_ok,
  input logic wr_ok
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  a_r1_output_needs_read: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> $past(!ce_n && !oe_n && we_n && hsb_n));

  a_r2_write_marks_dirty: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> dirty);

  a_r3_write_kills_output: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> !dout_en);

  a_r4_no_access_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!rd_ok && !wr_ok));

  a_r6_copy_not_too_long: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len <= DEPTH));

  a_r6_copy_full_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(run_len) == DEPTH));

  a_r7_clean_pin_edge_noop: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(hsb_n) && !hsb_n && !dirty && !pwr_fail) |=> !busy);
endmodule

bind nvsram_ctrl nvsram_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .hsb_n(hsb_n), .pwr_fail(pwr_fail), .busy(busy), .dout_en(dout_en),
  .dirty(dirty), .rd_ok(rd_ok), .wr_ok(wr_ok)
);

// File: tb/sim_nvsram_ctrl.sv
`timescale 1ns/1ps
module sim_nvsram_ctrl;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int D  = 1 << AW;
  localparam int SEQ [6] = '{56, 7, 32, 31, 63, 0};

  logic clk = 0, rst = 1;
  logic ce_n = 1, oe_n = 1, we_n = 1, hsb_n = 1, pwr_fail = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy;

  int nvec = 0, nfail = 0;
  bit started = 0, finished = 0;
  string cur_req = "R5";

  always #5 clk = ~clk;

  nvsram_ctrl u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hsb_n(hsb_n), .pwr_fail(pwr_fail), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  // Behavioural reference: 0 idle, 1 copying, 2 parked
  int        m_mode, m_left, m_step;
  bit        m_dirty, m_hprev, m_halt_after, e_den;
  logic [DW-1:0] m_ram [D];
  logic [DW-1:0] m_shd [D];
  logic [DW-1:0] e_dout;
  bit rd, wr, hit, fall, start;

  initial for (int i = 0; i < D; i++) m_shd[i] = '0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_mode = 1; m_left = D + 1; m_dirty = 0; m_step = 0;
      m_hprev = 1; m_halt_after = 0; e_den = 0;
      for (int i = 0; i < D; i++) m_ram[i] = m_shd[i];
    end else begin
      rd = (m_mode == 0) && !ce_n && !oe_n && we_n && hsb_n;
      wr = (m_mode == 0) && !ce_n && !we_n && hsb_n;
      fall = m_hprev && !hsb_n;
      m_hprev = hsb_n;
      e_den = rd;
      if (rd) e_dout = m_ram[addr];
      hit = 0;
      if (rd) begin
        if (int'(addr) == SEQ[m_step]) begin
          if (m_step == 5) begin hit = 1; m_step = 0; end
          else m_step++;
        end else m_step = 0;
      end
      start = 0;
      if (m_mode == 0) begin
        if (pwr_fail) begin
          if (m_dirty) begin start = 1; m_halt_after = 1; end
          else m_mode = 2;
        end else if ((fall && m_dirty) || hit) start = 1;
      end else if (m_mode == 1) begin
        m_left--;
        if (m_left == 0) begin
          m_dirty = 0;
          m_mode = m_halt_after ? 2 : 0;
        end
      end
      if (wr) begin m_ram[addr] = din; m_dirty = 1; end
      if (start) begin
        for (int i = 0; i < D; i++) m_shd[i] = m_ram[i];
        m_mode = 1; m_left = D + 1;
      end
    end
  end

  task automatic check(string req, string what, int got, int exp);
    nvec++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      check(cur_req, "model busy", int'(busy), int'(m_mode == 1));
      check(cur_req, "model dout_en", int'(dout_en), int'(e_den));
      if (e_den) check(cur_req, "model dout", int'(dout), int'(e_dout));
    end
  end

  task automatic wr_byte(int a, int d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = AW'(a); din = DW'(d);
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rd_only(int a);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = AW'(a);
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    rd_only(a);
    check(req, "read enable", int'(dout_en), 1);
    check(req, "read data", int'(dout), exp);
  endtask

  task automatic hsb_pulse();
    @(negedge clk); hsb_n = 0;
    @(negedge clk); hsb_n = 1;
  endtask

  task automatic wait_free();
    for (int i = 0; i < 4 * D && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    wait_free();
  endtask

  task automatic run_seq();
    for (int i = 0; i < 6; i++) rd_only(SEQ[i]);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    cur_req = "R5";
    check("R5", "busy in reset", int'(busy), 1);
    check("R5", "dout_en in reset", int'(dout_en), 0);
    rst = 0;
    wait_free();
    rd_chk("R5", 5, 0);

    cur_req = "R2";
    wr_byte(3, 'h5A); wr_byte(10, 'hC3); wr_byte(63, 'h81); wr_byte(0, 'h11);
    rd_chk("R1", 3, 'h5A); rd_chk("R1", 63, 'h81); rd_chk("R2", 0, 'h11);

    cur_req = "R3";
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; addr = 6'd2; din = 8'h3C;
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
    check("R3", "dout_en with we_n low", int'(dout_en), 0);
    rd_chk("R3", 2, 'h3C);

    cur_req = "R7";
    hsb_pulse();
    check("R7", "dirty pin store", int'(busy), 1);
    cur_req = "R4";
    wr_byte(1, 'hEE);
    rd_only(1);
    check("R4", "read during copy", int'(dout_en), 0);
    cur_req = "R12";
    hsb_pulse();
    wait_free();
    repeat (2) @(negedge clk);
    check("R12", "no second store", int'(busy), 0);
    rd_chk("R4", 1, 0);

    cur_req = "R11";
    hsb_pulse();
    check("R11", "clean pin edge", int'(busy), 0);

    cur_req = "R13";
    wr_byte(3, 'h77);
    rd_chk("R13", 3, 'h77);
    do_reset();
    rd_chk("R13", 3, 'h5A); rd_chk("R13", 10, 'hC3); rd_chk("R13", 2, 'h3C);

    cur_req = "R9";
    rd_only(SEQ[0]); rd_only(SEQ[1]); rd_only(SEQ[2]); rd_only(5);
    rd_only(SEQ[3]); rd_only(SEQ[4]); rd_only(SEQ[5]);
    check("R9", "broken pattern", int'(busy), 0);

    cur_req = "R8";
    run_seq();
    check("R8", "pattern store on clean ram", int'(busy), 1);
    wait_free();
    wr_byte(20, 'h42);
    run_seq();
    cur_req = "R6";
    check("R6", "store running", int'(busy), 1);
    wait_free();
    do_reset();
    rd_chk("R8", 20, 'h42);

    cur_req = "R10";
    @(negedge clk); pwr_fail = 1;
    @(negedge clk);
    check("R10", "clean power fail", int'(busy), 0);
    rd_only(3);
    check("R10", "parked read", int'(dout_en), 0);
    pwr_fail = 0;
    do_reset();
    wr_byte(7, 'h99);
    @(negedge clk); pwr_fail = 1;
    @(negedge clk);
    check("R10", "dirty power fail store", int'(busy), 1);
    wait_free();
    wr_byte(7, 'h00);
    rd_only(7);
    check("R10", "parked after store", int'(dout_en), 0);
    check("R10", "parked busy", int'(busy), 0);
    pwr_fail = 0;
    do_reset();
    rd_chk("R10", 7, 'h99);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule